// File: doc/BRIEF.md
# Page-Mask Translation Lookaside Buffer

This block is a fully associative translation cache for a paged memory system. Each of its `N_ENT` slots maps one naturally aligned pair of virtual pages onto two physical frames. The pages are called even and odd. Each slot holds a per-slot page-size mask, an address-space tag, and a global flag that lets the slot serve every address space. The frame of each half carries its own cache-attribute code, dirty flag and valid flag.

A core drives the translate port every cycle and gets back, in the same cycle, one of three outcomes:
- hit, with the slot number, physical address and attributes;
- invalid-page, when a slot matches but the chosen half is not valid;
- miss.

A second compare path answers probe queries with a slot number or an all-ones miss code. Slots are loaded and inspected through indexed write and read ports. A replacement pointer walks the slots for victim selection. A flush empties the table. A fixed address-pattern test flags uncached, strictly ordered regions.

The ports carry no back-pressure. `lk_valid` qualifies a translate request, and the result is produced combinationally in the same cycle. The block always accepts a request, so no ready signal exists. Writes, flushes and pointer moves take effect on the rising clock edge.

Top module: `pmask_tlb`

## Requirements
- R1: A slot matches a query when it is live and its stored VPN equals the query VPN (`lk_vaddr[31:13]` or `pr_vpn`) in every bit where the slot's mask is 0. Bits where the mask is 1 are not compared.
- R2: A match also needs the slot's global flag set, or the query tag equal to the stored tag. The global flag is set only when bit 0 of both `wr_lo0` and `wr_lo1` was 1 at write time. It reads back in bit 0 of both `rd_lo0` and `rd_lo1`.
- R3: `pr_result` is `{1'b0, slot}` for a matching slot, or all ones when no slot matches.
- R4: When several slots match, the lowest slot number is reported by both lookup and probe.
- R5: A write with `wr_en` and `wr_idx < N_ENT` replaces the whole slot, and the new contents are visible from the next cycle. The read-back layouts are:
  - `rd_hi`: VPN at bit 11 and up, tag in bits 7:0, bits 10:8 zero.
  - `rd_lo0` and `rd_lo1`: frame at bit 6 and up, attribute code at bits 5:3, dirty flag at bit 2, valid flag at bit 1, global flag at bit 0. The write words `wr_lo0` and `wr_lo1` use the same layout.
  - `rd_mask`: the mask shifted left by 11.
- R6: A write with `wr_idx >= N_ENT` changes no slot.
- R7: A slot whose two valid flags are both clear is not live. It never produces a lookup hit, an invalid-page result or a probe match.
- R8: The mask is k contiguous ones from bit 0. With such a mask, virtual address bit 12+k selects the odd half (1) or the even half (0).
  - `lk_paddr` is the chosen frame with its low k bits replaced by `lk_vaddr[12+k-1:12]`, followed by `lk_vaddr[11:0]`.
  - `lk_cattr` and `lk_dirty` come from the chosen half.
- R9: When a slot matches but the valid flag of the chosen half is clear, `lk_inval` is 1 and `lk_hit` is 0.
- R10: `lk_uncached` is 1 exactly when `lk_vaddr` bits 31 and 29 are both 1, whatever the table holds.
- R11: While `rd_adv` is 1, the read port shows the slot at `repl_ptr`, not the one at `rd_idx`. The pointer then advances by one at the clock edge and wraps from `N_ENT-1` to 0.
- R12: `flush` empties every slot and zeroes `repl_ptr` at the next edge, and it wins over a write in the same cycle.
- R13: Synchronous reset `rst` empties every slot and zeroes `repl_ptr`.
- R14: With `lk_valid` low, `lk_hit` and `lk_inval` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Translate request qualifier |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_hit | output | 1 | Valid translation found |
| lk_inval | output | 1 | Slot matched, chosen half invalid |
| lk_idx | output | IDX_W | Matching slot number |
| lk_paddr | output | PFN_W+POFF_W | Physical address |
| lk_cattr | output | 3 | Cache-attribute code of chosen half |
| lk_dirty | output | 1 | Dirty flag of chosen half |
| lk_uncached | output | 1 | Address lies in the uncached, strictly ordered region |
| pr_vpn | input | VPN_W | Probe VPN (page-pair number) |
| pr_asid | input | ASID_W | Probe tag |
| pr_result | output | IDX_W+1 | Matching slot or all-ones miss code |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W+1 | Slot to write |
| wr_vpn | input | VPN_W | VPN to store |
| wr_asid | input | ASID_W | Tag to store |
| wr_mask | input | VPN_W | Page-size mask to store |
| wr_lo0 | input | PFN_W+6 | Even half word |
| wr_lo1 | input | PFN_W+6 | Odd half word |
| rd_idx | input | IDX_W | Slot to read |
| rd_adv | input | 1 | Read at pointer and advance it |
| rd_hi | output | 11+VPN_W | VPN and tag read-back |
| rd_mask | output | 11+VPN_W | Mask read-back |
| rd_lo0 | output | PFN_W+6 | Even half read-back |
| rd_lo1 | output | PFN_W+6 | Odd half read-back |
| repl_ptr | output | IDX_W | Replacement pointer |
| flush | input | 1 | Empty the table |

## Verification
The following outputs are combinational: lookup outcome, physical address, attributes, uncached flag, probe result and read-back words. They are due in the cycle their inputs are applied, so the bench sets the inputs well after a clock edge and samples after a short settle delay, with no edge in between. Writes, flushes, resets and pointer steps land at the rising edge after the cycle in which they are driven. The bench therefore drives them on a falling edge, waits through exactly one rising edge, and checks on the next falling edge. It checks both the new state (read-back, probe, pointer) and the absence of side effects on other slots.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // read-back layout
  localparam int HI_VPN_LSB    = 11;
  localparam int MASK_RD_SHIFT = 11;
  // stored half-word attribute layout (global flag kept apart)
  localparam int ATTR_V     = 0;
  localparam int ATTR_D     = 1;
  localparam int ATTR_C_LSB = 2;
  localparam int ATTR_C_W   = 3;
  localparam int ATTR_PFN   = 5;
  // uncached region pattern
  localparam logic [31:0] UNC_PATTERN = 32'hA000_0000;

  typedef enum logic [1:0] {LK_MISS, LK_HIT, LK_INVAL} lk_res_e;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int ATTR_W = 25,
  parameter int IDX_W  = 3,
  parameter int WIDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [WIDX_W-1:0]            wr_idx,
  input  logic [VPN_W-1:0]             wr_vpn,
  input  logic [ASID_W-1:0]            wr_asid,
  input  logic [VPN_W-1:0]             wr_mask,
  input  logic                         wr_g,
  input  logic [ATTR_W-1:0]            wr_a0,
  input  logic [ATTR_W-1:0]            wr_a1,
  input  logic                         adv,
  output logic [N-1:0][VPN_W-1:0]      e_vpn,
  output logic [N-1:0][ASID_W-1:0]     e_asid,
  output logic [N-1:0][VPN_W-1:0]      e_mask,
  output logic [N-1:0]                 e_g,
  output logic [N-1:0][ATTR_W-1:0]     e_a0,
  output logic [N-1:0][ATTR_W-1:0]     e_a1,
  output logic [IDX_W-1:0]             ptr
);
  logic in_range;
  assign in_range = wr_idx < WIDX_W'(N);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      e_vpn  <= '0;
      e_asid <= '0;
      e_mask <= '0;
      e_g    <= '0;
      e_a0   <= '0;
      e_a1   <= '0;
      ptr    <= '0;
    end else begin
      if (wr_en && in_range) begin
        e_vpn [wr_idx[IDX_W-1:0]] <= wr_vpn;
        e_asid[wr_idx[IDX_W-1:0]] <= wr_asid;
        e_mask[wr_idx[IDX_W-1:0]] <= wr_mask;
        e_g   [wr_idx[IDX_W-1:0]] <= wr_g;
        e_a0  [wr_idx[IDX_W-1:0]] <= wr_a0;
        e_a1  [wr_idx[IDX_W-1:0]] <= wr_a1;
      end
      if (adv) ptr <= (ptr == IDX_W'(N-1)) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  input  logic [N-1:0][VPN_W-1:0]  e_vpn,
  input  logic [N-1:0][ASID_W-1:0] e_asid,
  input  logic [N-1:0][VPN_W-1:0]  e_mask,
  input  logic [N-1:0]             e_g,
  input  logic [N-1:0]             e_live,
  output logic [N-1:0]             match
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic vpn_eq, tag_ok;
    assign vpn_eq   = ((q_vpn ^ e_vpn[i]) & ~e_mask[i]) == '0;
    assign tag_ok   = e_g[i] || (q_asid == e_asid[i]);
    assign match[i] = e_live[i] && vpn_eq && tag_ok;
  end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pmask_tlb.sv
module pmask_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int VA_W   = 32,
  parameter int POFF_W = 12,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  localparam int VPN_W  = VA_W - POFF_W - 1,
  localparam int PN_W   = VA_W - POFF_W,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int WIDX_W = IDX_W + 1,
  localparam int LO_W   = PFN_W + 6,
  localparam int ATTR_W = LO_W - 1,
  localparam int HI_W   = HI_VPN_LSB + VPN_W,
  localparam int MRD_W  = MASK_RD_SHIFT + VPN_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic [ASID_W-1:0]       lk_asid,
  output logic                    lk_hit,
  output logic                    lk_inval,
  output logic [IDX_W-1:0]        lk_idx,
  output logic [PFN_W+POFF_W-1:0] lk_paddr,
  output logic [ATTR_C_W-1:0]     lk_cattr,
  output logic                    lk_dirty,
  output logic                    lk_uncached,
  input  logic [VPN_W-1:0]        pr_vpn,
  input  logic [ASID_W-1:0]       pr_asid,
  output logic [WIDX_W-1:0]       pr_result,
  input  logic                    wr_en,
  input  logic [WIDX_W-1:0]       wr_idx,
  input  logic [VPN_W-1:0]        wr_vpn,
  input  logic [ASID_W-1:0]       wr_asid,
  input  logic [VPN_W-1:0]        wr_mask,
  input  logic [LO_W-1:0]         wr_lo0,
  input  logic [LO_W-1:0]         wr_lo1,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic                    rd_adv,
  output logic [HI_W-1:0]         rd_hi,
  output logic [MRD_W-1:0]        rd_mask,
  output logic [LO_W-1:0]         rd_lo0,
  output logic [LO_W-1:0]         rd_lo1,
  output logic [IDX_W-1:0]        repl_ptr,
  input  logic                    flush
);
  logic [N_ENT-1:0][VPN_W-1:0]  e_vpn, e_mask;
  logic [N_ENT-1:0][ASID_W-1:0] e_asid;
  logic [N_ENT-1:0]             e_g, e_live;
  logic [N_ENT-1:0][ATTR_W-1:0] e_a0, e_a1;

  tlb_store #(.N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W), .ATTR_W(ATTR_W),
              .IDX_W(IDX_W), .WIDX_W(WIDX_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_mask(wr_mask), .wr_g(wr_lo0[0] & wr_lo1[0]),
    .wr_a0(wr_lo0[LO_W-1:1]), .wr_a1(wr_lo1[LO_W-1:1]),
    .adv(rd_adv),
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_g(e_g),
    .e_a0(e_a0), .e_a1(e_a1), .ptr(repl_ptr)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_live
    assign e_live[i] = e_a0[i][ATTR_V] | e_a1[i][ATTR_V];
  end

  // translate path
  logic [N_ENT-1:0] lk_match;
  logic             lk_any;
  tlb_cam #(.N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
    .q_vpn(lk_vaddr[VA_W-1:POFF_W+1]), .q_asid(lk_asid),
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_g(e_g),
    .e_live(e_live), .match(lk_match)
  );
  tlb_first #(.N(N_ENT), .IDX_W(IDX_W)) u_first_lk (
    .vec(lk_match), .any(lk_any), .idx(lk_idx)
  );

  logic [PN_W-1:0]   m_ext, sel_bit, low_bits, va_pn;
  logic              odd;
  logic [ATTR_W-1:0] a_sel;
  logic [PFN_W-1:0]  pfn_out;
  lk_res_e           res;

  always_comb begin
    va_pn    = lk_vaddr[VA_W-1:POFF_W];
    m_ext    = {e_mask[lk_idx], 1'b1};
    sel_bit  = m_ext & ~(m_ext >> 1);
    low_bits = m_ext >> 1;
    odd      = |(va_pn & sel_bit);
    a_sel    = odd ? e_a1[lk_idx] : e_a0[lk_idx];
    pfn_out  = (a_sel[ATTR_W-1:ATTR_PFN] & ~PFN_W'(low_bits))
             | PFN_W'(va_pn & low_bits);
    if (!lk_valid || !lk_any) res = LK_MISS;
    else if (a_sel[ATTR_V])   res = LK_HIT;
    else                      res = LK_INVAL;
  end

  assign lk_hit      = (res == LK_HIT);
  assign lk_inval    = (res == LK_INVAL);
  assign lk_paddr    = {pfn_out, lk_vaddr[POFF_W-1:0]};
  assign lk_cattr    = a_sel[ATTR_C_LSB +: ATTR_C_W];
  assign lk_dirty    = a_sel[ATTR_D];
  assign lk_uncached = (lk_vaddr & VA_W'(UNC_PATTERN)) == VA_W'(UNC_PATTERN);

  // probe path
  logic [N_ENT-1:0] pr_match;
  logic             pr_any;
  logic [IDX_W-1:0] pr_idx;
  tlb_cam #(.N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_pr (
    .q_vpn(pr_vpn), .q_asid(pr_asid),
    .e_vpn(e_vpn), .e_asid(e_asid), .e_mask(e_mask), .e_g(e_g),
    .e_live(e_live), .match(pr_match)
  );
  tlb_first #(.N(N_ENT), .IDX_W(IDX_W)) u_first_pr (
    .vec(pr_match), .any(pr_any), .idx(pr_idx)
  );
  assign pr_result = pr_any ? {1'b0, pr_idx} : '1;

  // read-back
  logic [IDX_W-1:0] rd_addr;
  assign rd_addr = rd_adv ? repl_ptr : rd_idx;
  assign rd_hi   = (HI_W'(e_vpn[rd_addr]) << HI_VPN_LSB) | HI_W'(e_asid[rd_addr]);
  assign rd_mask = MRD_W'(e_mask[rd_addr]) << MASK_RD_SHIFT;
  assign rd_lo0  = {e_a0[rd_addr], e_g[rd_addr]};
  assign rd_lo1  = {e_a1[rd_addr], e_g[rd_addr]};
endmodule

// File: rtl/pmask_tlb_chk.sv
module pmask_tlb_chk #(
  parameter int N_ENT  = 8,
  parameter int VA_W   = 32,
  parameter int POFF_W = 12,
  parameter int ASID_W = 8,
  parameter int IDX_W  = 3,
  parameter int WIDX_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_inval,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [VA_W-POFF_W-2:0] pr_vpn,
  input logic [ASID_W-1:0] pr_asid,
  input logic [WIDX_W-1:0] pr_result,
  input logic              rd_adv,
  input logic [IDX_W-1:0]  repl_ptr,
  input logic              flush
);
  // R9: the two lookup outcomes never coincide
  a_r9_hit_inval_excl: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_inval));

  // R14: an idle request yields no outcome
  a_r14_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_inval));

  // R3: probe returns a slot in range or the miss code
  a_r3_probe_code: assert property (@(posedge clk) disable iff (rst)
    (pr_result == '1) || (pr_result < WIDX_W'(N_ENT)));

  // R4: both compare paths agree on the same query
  a_r4_paths_agree: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && pr_vpn == lk_vaddr[VA_W-1:POFF_W+1] && pr_asid == lk_asid)
    |-> ((lk_hit || lk_inval) ? (pr_result == {1'b0, lk_idx}) : (pr_result == '1)));

  // R12: after a flush the table is empty and the pointer is zero
  a_r12_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (flush) |=> (repl_ptr == '0 && pr_result == '1 && !lk_hit && !lk_inval));

  // R11: pointer steps by one and wraps
  a_r11_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_adv && !flush) |=>
      (repl_ptr == (($past(repl_ptr) == IDX_W'(N_ENT-1)) ? '0 : $past(repl_ptr) + 1'b1)));
endmodule

bind pmask_tlb pmask_tlb_chk #(
  .N_ENT(N_ENT), .VA_W(VA_W), .POFF_W(POFF_W), .ASID_W(ASID_W),
  .IDX_W(IDX_W), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_inval(lk_inval), .lk_idx(lk_idx),
  .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_result(pr_result),
  .rd_adv(rd_adv), .repl_ptr(repl_ptr), .flush(flush)
);

// File: tb/pmask_tlb_tb.sv
module pmask_tlb_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        lk_hit, lk_inval, lk_dirty, lk_uncached;
  logic [2:0]  lk_idx, lk_cattr;
  logic [31:0] lk_paddr;
  logic [18:0] pr_vpn;
  logic [7:0]  pr_asid;
  logic [3:0]  pr_result;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [18:0] wr_vpn, wr_mask;
  logic [7:0]  wr_asid;
  logic [25:0] wr_lo0, wr_lo1;
  logic [2:0]  rd_idx;
  logic        rd_adv;
  logic [29:0] rd_hi, rd_mask;
  logic [25:0] rd_lo0, rd_lo1;
  logic [2:0]  repl_ptr;
  logic        flush;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmask_tlb u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_inval(lk_inval), .lk_idx(lk_idx),
    .lk_paddr(lk_paddr), .lk_cattr(lk_cattr), .lk_dirty(lk_dirty),
    .lk_uncached(lk_uncached), .pr_vpn(pr_vpn), .pr_asid(pr_asid),
    .pr_result(pr_result), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .rd_idx(rd_idx), .rd_adv(rd_adv), .rd_hi(rd_hi), .rd_mask(rd_mask),
    .rd_lo0(rd_lo0), .rd_lo1(rd_lo1), .repl_ptr(repl_ptr), .flush(flush)
  );

  function automatic logic [25:0] mk_lo(logic [19:0] pfn, logic [2:0] c,
                                        logic d, logic v, logic g);
    return {pfn, c, d, v, g};
  endfunction

  function automatic logic [29:0] mk_hi(logic [18:0] vpn, logic [7:0] asid);
    return {vpn, 3'b000, asid};
  endfunction

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [18:0] vpn,
                          input logic [7:0] asid, input logic [18:0] mask,
                          input logic [25:0] lo0, input logic [25:0] lo1);
    @(negedge clk);
    wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_mask = mask;
    wr_lo0 = lo0; wr_lo1 = lo1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid);
    lk_vaddr = va; lk_asid = asid; #1;
  endtask

  task automatic probe(input logic [18:0] vpn, input logic [7:0] asid);
    pr_vpn = vpn; pr_asid = asid; #1;
  endtask

  task automatic t_reset;
    probe(19'h0, 8'h0);
    check("R13 probe empty", pr_result, 4'hF);
    check("R13 pointer", repl_ptr, 0);
    rd_idx = 3'd0; #1;
    check("R13 slot0 hi", rd_hi, 0);
    check("R13 slot0 lo0", rd_lo0, 0);
    look(32'h0, 8'h0);
    check("R13 no hit", {lk_hit, lk_inval}, 0);
  endtask

  task automatic t_basic;
    do_write(4'd2, 19'h00123, 8'h05, 19'h0, mk_lo(20'hABCDE, 3'd3, 1'b1, 1'b1, 1'b0),
             mk_lo(20'h11111, 3'd2, 1'b0, 1'b1, 1'b0));
    rd_idx = 3'd2; #1;
    check("R5 hi readback", rd_hi, mk_hi(19'h00123, 8'h05));
    check("R5 lo0 readback", rd_lo0, mk_lo(20'hABCDE, 3'd3, 1'b1, 1'b1, 1'b0));
    check("R5 lo1 readback", rd_lo1, mk_lo(20'h11111, 3'd2, 1'b0, 1'b1, 1'b0));
    look({19'h00123, 1'b0, 12'h345}, 8'h05);
    check("R1 even hit", {lk_hit, lk_inval, lk_idx}, {2'b10, 3'd2});
    check("R8 even paddr", lk_paddr, 32'hABCDE345);
    check("R8 even attrs", {lk_cattr, lk_dirty}, {3'd3, 1'b1});
    look({19'h00123, 1'b1, 12'h345}, 8'h05);
    check("R8 odd paddr", lk_paddr, 32'h11111345);
    check("R8 odd attrs", {lk_cattr, lk_dirty}, {3'd2, 1'b0});
    look({19'h00123, 1'b0, 12'h345}, 8'h06);
    check("R2 tag mismatch miss", {lk_hit, lk_inval}, 0);
    probe(19'h00123, 8'h05);
    check("R3 probe hit", pr_result, 4'd2);
    probe(19'h00124, 8'h05);
    check("R3 probe miss code", pr_result, 4'hF);
  endtask

  task automatic t_global;
    do_write(4'd3, 19'h00200, 8'h09, 19'h0, mk_lo(20'h22222, 3'd0, 1'b0, 1'b1, 1'b1),
             mk_lo(20'h22223, 3'd0, 1'b0, 1'b1, 1'b1));
    look({19'h00200, 1'b0, 12'h000}, 8'h44);
    check("R2 global hit", {lk_hit, lk_idx}, {1'b1, 3'd3});
    rd_idx = 3'd3; #1;
    check("R2 global readback", rd_lo1, mk_lo(20'h22223, 3'd0, 1'b0, 1'b1, 1'b1));
    do_write(4'd4, 19'h00300, 8'h09, 19'h0, mk_lo(20'h33333, 3'd0, 1'b0, 1'b1, 1'b1),
             mk_lo(20'h33334, 3'd0, 1'b0, 1'b1, 1'b0));
    look({19'h00300, 1'b0, 12'h000}, 8'h44);
    check("R2 half global ignored", {lk_hit, lk_inval}, 0);
    look({19'h00300, 1'b0, 12'h000}, 8'h09);
    check("R2 tag hit", {lk_hit, lk_idx}, {1'b1, 3'd4});
    rd_idx = 3'd4; #1;
    check("R2 global reads 0", rd_lo0, mk_lo(20'h33333, 3'd0, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_mask;
    do_write(4'd5, 19'h00400, 8'h01, 19'h3, mk_lo(20'h50000, 3'd1, 1'b0, 1'b1, 1'b0),
             mk_lo(20'h60000, 3'd4, 1'b1, 1'b1, 1'b0));
    rd_idx = 3'd5; #1;
    check("R5 mask readback", rd_mask, 30'h1800);
    look(32'h00806ABC, 8'h01);
    check("R1 masked hit", {lk_hit, lk_idx}, {1'b1, 3'd5});
    check("R8 large odd paddr", lk_paddr, 32'h60002ABC);
    check("R8 large odd attrs", {lk_cattr, lk_dirty}, {3'd4, 1'b1});
    look(32'h00803ABC, 8'h01);
    check("R8 large even paddr", lk_paddr, 32'h50003ABC);
    look(32'h00808000, 8'h01);
    check("R1 unmasked bit differs", {lk_hit, lk_inval}, 0);
  endtask

  task automatic t_prio;
    do_write(4'd6, 19'h00700, 8'h02, 19'h0, mk_lo(20'h77776, 3'd0, 1'b0, 1'b1, 1'b0),
             mk_lo(20'h77777, 3'd0, 1'b0, 1'b1, 1'b0));
    do_write(4'd1, 19'h00700, 8'h02, 19'h0, mk_lo(20'h11110, 3'd0, 1'b0, 1'b1, 1'b0),
             mk_lo(20'h11112, 3'd0, 1'b0, 1'b1, 1'b0));
    look({19'h00700, 1'b0, 12'h000}, 8'h02);
    check("R4 lookup lowest", {lk_idx, lk_paddr}, {3'd1, 32'h11110000});
    probe(19'h00700, 8'h02);
    check("R4 probe lowest", pr_result, 4'd1);
  endtask

  task automatic t_inval;
    do_write(4'd7, 19'h00800, 8'h03, 19'h0, mk_lo(20'h88880, 3'd0, 1'b0, 1'b1, 1'b0),
             mk_lo(20'h88881, 3'd0, 1'b0, 1'b0, 1'b0));
    look({19'h00800, 1'b1, 12'h000}, 8'h03);
    check("R9 odd invalid", {lk_hit, lk_inval, lk_idx}, {2'b01, 3'd7});
    look({19'h00800, 1'b0, 12'h000}, 8'h03);
    check("R9 even valid", {lk_hit, lk_inval}, 2'b10);
    do_write(4'd0, 19'h00900, 8'h03, 19'h0, mk_lo(20'h99990, 3'd0, 1'b0, 1'b0, 1'b0),
             mk_lo(20'h99991, 3'd0, 1'b0, 1'b0, 1'b0));
    look({19'h00900, 1'b0, 12'h000}, 8'h03);
    check("R7 dead slot lookup", {lk_hit, lk_inval}, 0);
    probe(19'h00900, 8'h03);
    check("R7 dead slot probe", pr_result, 4'hF);
  endtask

  task automatic t_idle;
    lk_valid = 1'b0;
    look({19'h00123, 1'b0, 12'h345}, 8'h05);
    check("R14 idle no outcome", {lk_hit, lk_inval}, 0);
    lk_valid = 1'b1;
  endtask

  task automatic t_oob;
    do_write(4'd8, 19'h00A00, 8'h03, 19'h0, mk_lo(20'hAAAAA, 3'd0, 1'b0, 1'b1, 1'b0),
             mk_lo(20'hAAAAB, 3'd0, 1'b0, 1'b1, 1'b0));
    probe(19'h00A00, 8'h03);
    check("R6 oob not stored", pr_result, 4'hF);
    rd_idx = 3'd0; #1;
    check("R6 slot0 kept", rd_hi, mk_hi(19'h00900, 8'h03));
  endtask

  task automatic t_uncached;
    look(32'hA000_0000, 8'h0); check("R10 base", lk_uncached, 1);
    look(32'hBFFF_F000, 8'h0); check("R10 top", lk_uncached, 1);
    look(32'hE000_0000, 8'h0); check("R10 upper", lk_uncached, 1);
    look(32'h8000_0000, 8'h0); check("R10 bit29 clear", lk_uncached, 0);
    look(32'h2000_0000, 8'h0); check("R10 bit31 clear", lk_uncached, 0);
  endtask

  task automatic t_ptr;
    @(negedge clk);
    rd_idx = 3'd5; rd_adv = 1'b1; #1;
    check("R11 reads at pointer", rd_hi, mk_hi(19'h00900, 8'h03));
    @(negedge clk); #1;
    check("R11 step", repl_ptr, 1);
    check("R11 read slot1", rd_hi, mk_hi(19'h00700, 8'h02));
    repeat (6) @(negedge clk);
    #1 check("R11 last slot", repl_ptr, 7);
    @(negedge clk); #1;
    check("R11 wrap", repl_ptr, 0);
    repeat (2) @(negedge clk);
    rd_adv = 1'b0;
    @(negedge clk); #1;
    check("R11 hold", repl_ptr, 2);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1; wr_en = 1'b1; wr_idx = 4'd2; wr_vpn = 19'h00555; wr_asid = 8'h05;
    wr_mask = 19'h0; wr_lo0 = mk_lo(20'h55555, 3'd0, 1'b0, 1'b1, 1'b0); wr_lo1 = wr_lo0;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0; #1;
    check("R12 pointer zero", repl_ptr, 0);
    rd_idx = 3'd2; #1;
    check("R12 slot2 cleared", {rd_hi, rd_lo0}, 0);
    probe(19'h00555, 8'h05);
    check("R12 flush beats write", pr_result, 4'hF);
    probe(19'h00123, 8'h05);
    check("R12 old slot gone", pr_result, 4'hF);
    look({19'h00200, 1'b0, 12'h000}, 8'h44);
    check("R12 global gone", {lk_hit, lk_inval}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_valid = 1'b1; lk_vaddr = '0; lk_asid = '0;
    pr_vpn = '0; pr_asid = '0; wr_en = 1'b0; wr_idx = '0; wr_vpn = '0;
    wr_asid = '0; wr_mask = '0; wr_lo0 = '0; wr_lo1 = '0;
    rd_idx = '0; rd_adv = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_global;
    t_mask;
    t_prio;
    t_inval;
    t_idle;
    t_oob;
    t_uncached;
    t_ptr;
    t_flush;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule